// File: doc/BRIEF.md
# Serial Panel Register Writer

This block programs the configuration registers of a display panel over a three-wire serial link. The link has an active-low enable line, a serial clock that idles high, and a data line. A client places an 8-bit register address and an 8-bit value on the inputs and pulses a start strobe. The block then shifts out one 16-bit frame and reports completion. The panel latches each data bit on the rising edge of the serial clock.

A two-bit job selector picks what a start request does. It can send the client's single write. It can play back a fixed five-write power-up program. It can send a one-write power-down command. The clock rate on the link comes from dividing the system clock: a parameter sets how many system cycles each half of the serial clock period lasts. Busy stays high from the accepted request until the enable line is high again after the last frame of the job. A one-cycle done pulse marks the end of the job.

Top module: `spw_panel_writer`

## Requirements
- R1: After reset, enable is high, serial clock is high, data is low, and busy and done are both low.
- R2: Each frame carries 16 bits, most significant bit first. The register address fills bits 15..8 and the value fills bits 7..0. The panel samples data on each rising edge of the serial clock while enable is low.
- R3: Enable falls only while the clock is high and data is low. Enable rises again after exactly 16 rising clock edges, and the clock is high when it rises.
- R4: While enable stays low, the data line changes only in the cycle in which the serial clock falls.
- R5: Each low phase and each high phase of the serial clock inside a frame lasts exactly HALF_DIV system clock cycles.
- R6: Busy goes high in the cycle after an accepted start. It stays high until enable has returned high after the job's last frame.
- R7: Done is high for exactly one cycle. Done rises in the same cycle in which busy falls.
- R8: A start request while busy is high has no effect. It adds no frame and does not change the frames of the job in progress.
- R9: Job code 2'b01 sends five frames in this order: 0x051E, 0x055E, 0x078D, 0x1301, 0x055F.
- R10: Job code 2'b10 sends the single frame 0x055E.
- R11: Job codes 2'b00 and 2'b11 send the single frame {addr_i, data_i}, with the address and value captured at the accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| job_i | input | 2 | Job select: 00/11 single write, 01 power-up program, 10 power-down command |
| addr_i | input | 8 | Register address for a single write |
| data_i | input | 8 | Register value for a single write |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle pulse at job end |
| sen_n_o | output | 1 | Serial enable, active low |
| sck_o | output | 1 | Serial clock, idles high |
| sda_o | output | 1 | Serial data |

## Verification
The bench targets the following failure modes:
- **Bit order and byte placement.** Single writes use all-zero, all-one and walking-bit bytes. A design that sends the frame LSB first or swaps the bytes produces frames that differ from the expected ones.
- **Power-up program.** The five frames are compared in order. A wrong table entry, a skipped step or an off-by-one stop count shows up as a wrong frame or a wrong frame count.
- **Strobe during a job.** A second strobe with different contents arrives mid-job. A design that accepts it would emit an extra frame or corrupt the current one.
- **Line timing.** The monitor checks the clock low-phase length, the data changes relative to the clock edges, and the enable edges against the line rules. This catches a data update at the rising edge, an early or late enable release, or a wrong divider.

// File: rtl/spw_pkg.sv
package spw_pkg;

  typedef enum logic [1:0] {
    JOB_SINGLE   = 2'b00,
    JOB_PWR_UP   = 2'b01,
    JOB_PWR_DOWN = 2'b10,
    JOB_SINGLE2  = 2'b11
  } job_e;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] data;
  } wr_s;

  localparam int unsigned FRAME_W   = $bits(wr_s);
  localparam int unsigned PWR_UP_N  = 5;
  localparam int unsigned IDX_W     = $clog2(PWR_UP_N);

  // Power-up program, step by step.
  function automatic wr_s pwr_up_step(input logic [IDX_W-1:0] idx);
    wr_s w;
    case (idx)
      3'd0:    w = '{addr: 8'h05, data: 8'h1E};
      3'd1:    w = '{addr: 8'h05, data: 8'h5E};
      3'd2:    w = '{addr: 8'h07, data: 8'h8D};
      3'd3:    w = '{addr: 8'h13, data: 8'h01};
      default: w = '{addr: 8'h05, data: 8'h5F};
    endcase
    return w;
  endfunction

  function automatic wr_s pwr_down_step();
    return '{addr: 8'h05, data: 8'h5E};
  endfunction

endpackage

// File: rtl/spw_half_tick.sv
module spw_half_tick #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/spw_step_table.sv
module spw_step_table
  import spw_pkg::*;
(
  input  job_e             job,
  input  logic [IDX_W-1:0] idx,
  input  wr_s              user_wr,
  output wr_s              step,
  output logic             last
);
  always_comb begin
    unique case (job)
      JOB_PWR_UP: begin
        step = pwr_up_step(idx);
        last = (idx == IDX_W'(PWR_UP_N - 1));
      end
      JOB_PWR_DOWN: begin
        step = pwr_down_step();
        last = 1'b1;
      end
      default: begin
        step = user_wr;
        last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/spw_frame_shifter.sv
module spw_frame_shifter
  import spw_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               launch,
  input  logic [FRAME_W-1:0] frame,
  output logic               frame_done,
  output logic               sen_n,
  output logic               sck,
  output logic               sda
);
  localparam int unsigned BW = $clog2(FRAME_W);

  typedef enum logic [2:0] {
    SH_IDLE, SH_SETUP, SH_ENA, SH_LO, SH_HI, SH_END
  } sh_e;

  sh_e                state;
  logic [FRAME_W-1:0] sreg;
  logic [BW-1:0]      bitn;
  logic               tick;

  spw_half_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (state != SH_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SH_IDLE;
      sreg       <= '0;
      bitn       <= '0;
      frame_done <= 1'b0;
      sen_n      <= 1'b1;
      sck        <= 1'b1;
      sda        <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        SH_IDLE: begin
          if (launch) begin
            sreg  <= frame;
            bitn  <= '0;
            state <= SH_SETUP;
          end
        end
        SH_SETUP: begin
          if (tick) begin
            sen_n <= 1'b0;
            state <= SH_ENA;
          end
        end
        SH_ENA: begin
          if (tick) begin
            sck   <= 1'b0;
            sda   <= sreg[FRAME_W-1];
            sreg  <= sreg << 1;
            state <= SH_LO;
          end
        end
        SH_LO: begin
          if (tick) begin
            sck   <= 1'b1;
            state <= SH_HI;
          end
        end
        SH_HI: begin
          if (tick) begin
            if (bitn == BW'(FRAME_W - 1)) begin
              sen_n <= 1'b1;
              sda   <= 1'b0;
              state <= SH_END;
            end else begin
              bitn  <= bitn + 1'b1;
              sck   <= 1'b0;
              sda   <= sreg[FRAME_W-1];
              sreg  <= sreg << 1;
              state <= SH_LO;
            end
          end
        end
        SH_END: begin
          if (tick) begin
            frame_done <= 1'b1;
            state      <= SH_IDLE;
          end
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spw_panel_writer.sv
module spw_panel_writer
  import spw_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic [1:0] job_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] data_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       sen_n_o,
  output logic       sck_o,
  output logic       sda_o
);
  typedef enum logic [1:0] {CT_IDLE, CT_LAUNCH, CT_WAIT} ct_e;

  ct_e              cstate;
  job_e             job_q;
  wr_s              user_q;
  logic [IDX_W-1:0] idx;
  wr_s              step;
  logic             last;
  logic             frame_done;

  spw_step_table u_table (
    .job     (job_q),
    .idx     (idx),
    .user_wr (user_q),
    .step    (step),
    .last    (last)
  );

  spw_frame_shifter #(.HALF_DIV(HALF_DIV)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .launch     (cstate == CT_LAUNCH),
    .frame      (step),
    .frame_done (frame_done),
    .sen_n      (sen_n_o),
    .sck        (sck_o),
    .sda        (sda_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cstate <= CT_IDLE;
      job_q  <= JOB_SINGLE;
      user_q <= '0;
      idx    <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (cstate)
        CT_IDLE: begin
          if (start_i) begin
            job_q  <= job_e'(job_i);
            user_q <= '{addr: addr_i, data: data_i};
            idx    <= '0;
            busy_o <= 1'b1;
            cstate <= CT_LAUNCH;
          end
        end
        CT_LAUNCH: cstate <= CT_WAIT;
        CT_WAIT: begin
          if (frame_done) begin
            if (last) begin
              busy_o <= 1'b0;
              done_o <= 1'b1;
              cstate <= CT_IDLE;
            end else begin
              idx    <= idx + 1'b1;
              cstate <= CT_LAUNCH;
            end
          end
        end
        default: cstate <= CT_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spw_panel_writer_chk.sv
module spw_panel_writer_chk (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic done_o,
  input logic sen_n_o,
  input logic sck_o,
  input logic sda_o
);
  // R3: the clock is high whenever enable is high
  assert_sck_high_idle_R3: assert property (@(posedge clk) disable iff (rst)
    sen_n_o |-> sck_o);

  // R3: enable falls only with clock high and data low
  assert_sen_fall_clean_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(sen_n_o) |-> (sck_o && !sda_o));

  // R4: data holds across a rising clock edge
  assert_sda_hold_rise_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(sck_o) |-> $stable(sda_o));

  // R4: inside a frame, data moves only together with a falling clock
  assert_sda_moves_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    (!sen_n_o && $past(!sen_n_o) && !$fell(sck_o)) |-> $stable(sda_o));

  // R6: a frame on the wire implies busy
  assert_busy_covers_frame_R6: assert property (@(posedge clk) disable iff (rst)
    !sen_n_o |-> busy_o);

  // R7: done lasts one cycle
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7: done coincides with the fall of busy
  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind spw_panel_writer spw_panel_writer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sen_n_o (sen_n_o),
  .sck_o   (sck_o),
  .sda_o   (sda_o)
);

// File: tb/spw_panel_writer_test.sv
module spw_panel_writer_test;
  localparam int unsigned HALF = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic [1:0] job_i = 2'b00;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] data_i = 8'h00;
  logic       busy_o, done_o, sen_n_o, sck_o, sda_o;

  spw_panel_writer #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .job_i(job_i),
    .addr_i(addr_i), .data_i(data_i), .busy_o(busy_o), .done_o(done_o),
    .sen_n_o(sen_n_o), .sck_o(sck_o), .sda_o(sda_o)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Line monitor
  logic [15:0] cap [0:15];
  int          cap_n = 0;
  logic [15:0] shv = '0;
  int          nbits = 0;
  int          lowlen = 0;
  int          highlen = 0;
  logic        p_s = 1'b1, p_k = 1'b1, p_d = 1'b0;
  bit          mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (p_s && !sen_n_o) begin
        chk(sck_o && !sda_o, "R3 enable fall levels", {sck_o, sda_o}, 2);
        shv = '0; nbits = 0; lowlen = 0; highlen = 0;
      end
      if (!sen_n_o && !p_s && (sda_o !== p_d) && !(p_k && !sck_o))
        chk(1'b0, "R4 data moved outside clock fall", sda_o, p_d);
      if (!sen_n_o && !sck_o) lowlen++;
      if (!sen_n_o && p_k && !sck_o && nbits > 0) begin
        chk(highlen == HALF, "R5 high phase length", highlen, HALF);
      end
      if (!sen_n_o && sck_o && !p_k) begin
        chk(lowlen == HALF, "R5 low phase length", lowlen, HALF);
        lowlen = 0; highlen = 0;
        shv = {shv[14:0], sda_o};
        nbits++;
      end
      if (!sen_n_o && sck_o && nbits > 0) highlen++;
      if (!p_s && sen_n_o) begin
        chk(nbits == 16, "R3 rising edges per frame", nbits, 16);
        chk(sck_o, "R3 clock high at enable rise", sck_o, 1);
        if (cap_n < 16) cap[cap_n] = shv;
        cap_n++;
      end
    end
    p_s = sen_n_o; p_k = sck_o; p_d = sda_o;
  end

  function automatic int exp_count(input logic [1:0] j);
    return (j == 2'b01) ? 5 : 1;
  endfunction

  function automatic logic [15:0] exp_frame(input logic [1:0] j, input int i,
                                            input logic [7:0] a, input logic [7:0] d);
    logic [15:0] prog [0:4];
    prog[0] = 16'h051E; prog[1] = 16'h055E; prog[2] = 16'h078D;
    prog[3] = 16'h1301; prog[4] = 16'h055F;
    case (j)
      2'b01:   return prog[i];
      2'b10:   return 16'h055E;
      default: return {a, d};
    endcase
  endfunction

  task automatic run_job(input logic [1:0] j, input logic [7:0] a, input logic [7:0] d,
                         input bit poke);
    int waited;
    int ne;
    string rq;
    rq = (j == 2'b01) ? "R9" : (j == 2'b10) ? "R10" : "R11";
    cap_n = 0;
    @(negedge clk);
    start_i = 1'b1; job_i = j; addr_i = a; data_i = d;
    @(negedge clk);
    start_i = 1'b0; addr_i = ~a; data_i = ~d; job_i = ~j;
    chk(busy_o == 1'b1, "R6 busy after start", busy_o, 1);
    waited = 0;
    while (!done_o && waited < 5000) begin
      if (poke && waited == 40) begin
        start_i = 1'b1; job_i = 2'b00; addr_i = 8'hA5; data_i = 8'h3C;
        @(negedge clk);
        start_i = 1'b0;
        waited++;
        continue;
      end
      chk(busy_o || done_o, "R6 busy held during job", busy_o, 1);
      @(negedge clk);
      waited++;
    end
    chk(done_o == 1'b1, "R7 done reached", done_o, 1);
    chk(busy_o == 1'b0, "R7 busy low with done", busy_o, 0);
    chk(sen_n_o == 1'b1, "R6 enable high at end", sen_n_o, 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    repeat (4 * HALF) @(negedge clk);
    ne = exp_count(j);
    chk(cap_n == ne, {rq, poke ? " R8" : "", " frame count"}, cap_n, ne);
    for (int i = 0; i < ne && i < cap_n; i++)
      chk(cap[i] == exp_frame(j, i, a, d), {rq, " R2 frame value"},
          cap[i], exp_frame(j, i, a, d));
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(sen_n_o == 1'b1, "R1 enable idle", sen_n_o, 1);
    chk(sck_o == 1'b1, "R1 clock idle", sck_o, 1);
    chk(sda_o == 1'b0, "R1 data idle", sda_o, 0);
    chk(busy_o == 1'b0, "R1 busy idle", busy_o, 0);
    chk(done_o == 1'b0, "R1 done idle", done_o, 0);
    p_s = sen_n_o; p_k = sck_o; p_d = sda_o;
    mon_on = 1'b1;

    // Directed corners
    run_job(2'b00, 8'h00, 8'hFF, 1'b0);   // R11 R2
    run_job(2'b11, 8'h80, 8'h01, 1'b0);   // R11 alt code
    run_job(2'b01, 8'h12, 8'h34, 1'b0);   // R9
    run_job(2'b10, 8'h77, 8'h66, 1'b0);   // R10
    run_job(2'b01, 8'h00, 8'h00, 1'b1);   // R8 poke during program
    run_job(2'b00, 8'hC3, 8'h5A, 1'b1);   // R8 poke during single write

    // Random jobs
    for (int t = 0; t < 30; t++) begin
      logic [1:0] jj;
      logic [7:0] aa, dd;
      jj = 2'($urandom_range(0, 3));
      aa = 8'($urandom);
      dd = 8'($urandom);
      run_job(jj, aa, dd, ($urandom_range(0, 3) == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule